// File: doc/BRIEF.md
# GPIO Interrupt Mask and Status Unit

This unit samples four general-purpose input pins, finds changes of level on them and merges the accepted changes into one active-high interrupt line. Each pin passes through a two-flop synchronising chain. A change between two samples in a row counts as an event. Both rising and falling changes count.

A per-pin enable mask decides which events are kept. An event on an enabled pin that is in input mode sets a sticky bit in a latched interrupt status register. An event on a disabled pin is dropped: it sets no status bit and does not touch the interrupt line. The synchronised pin levels can always be read, whatever the mask holds. A host reaches the registers over a small register bus with an address, write data, a write strobe and a read strobe. A read of the latched status register returns its contents and clears it.

Pin direction is decided outside this unit. It arrives as a per-pin input-mode flag.

Top module: `gpio_irq_unit`

## Requirements
- R1: The mask register is at address 0x30. Bits 3:0 hold one enable per pin, where bit i belongs to pin i. Bits 7:4 always read as zero. The register resets to 0, so every source starts disabled.
- R2: The live level register is at address 0x32. Its bit i reads the synchronised level of pin i, whatever the mask holds. A pin change shows up there two rising edges after it is applied.
- R3: A change of level on pin i sets bit i of the latched status register (address 0x33) on the third rising edge after the change, when mask bit i is 1 and the pin is in input mode.
- R4: When mask bit i is 0, a change on pin i leaves status bit i at 0 and does not raise the interrupt line.
- R5: A pin whose input-mode flag is 0 never sets its status bit, whatever its mask bit holds.
- R6: The interrupt line is high exactly when some status bit is 1 and its mask bit is also 1.
- R7: A read strobe to address 0x33 returns the status bits on rdata in bits 3:0 one cycle later. The same read clears every latched bit.
- R8: An event that lands in the same cycle as a clearing read is kept. The following read returns it.
- R9: Writes to any address other than 0x30 have no effect. Reads return zero for unmapped addresses, and rdata is zero in any cycle that follows no read strobe.
- R10: A rising change and a falling change on a pin both count as events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 4 | Raw asynchronous pin levels |
| pin_is_input_i | input | 4 | Per-pin input-mode flag from the direction logic |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume the following:
- Only one of the write and read strobes is active in a cycle.
- The input-mode flags and the mask stay steady while an event moves through the synchroniser.

The stimulus respects this:
- It writes the mask in its own cycle and then changes pin levels and mode flags together.
- It waits four clocks before it reads anything.
- The only overlap between an event and a read is the one directed case that checks R8.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register addresses for the GPIO interrupt unit.
// Assumes an 8-bit register address space.
package gpio_irq_pkg;
    localparam logic [7:0] ADDR_MASK   = 8'h30;
    localparam logic [7:0] ADDR_LEVEL  = 8'h32;
    localparam logic [7:0] ADDR_STATUS = 8'h33;

    // Register select decoded from a bus address.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_LEVEL  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            ADDR_MASK:   return SEL_MASK;
            ADDR_LEVEL:  return SEL_LEVEL;
            ADDR_STATUS: return SEL_STATUS;
            default:     return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: brings each raw pin into the clock domain through two flops.
// A third flop keeps the previous sample, and the module flags an event
// whenever the sample changes level. Assumes the pins are asynchronous and
// at least one clock wide. Reset clears all stages to 0.
module gpio_sync #(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] level_o,
    output logic [N_PINS-1:0] event_o
);
    logic [N_PINS-1:0] meta_q;
    logic [N_PINS-1:0] sync_q;
    logic [N_PINS-1:0] prev_q;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        // Synchroniser chain plus previous-sample flop for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= pin_i[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end

        // Any change of level between two samples in a row is an event.
        always_comb event_o[g] = sync_q[g] ^ prev_q[g];

        // R10: an event must line up with a real change seen one stage earlier.
        assert_event_tracks_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[g] |-> (sync_q[g] != $past(sync_q[g])));
    end

    assign level_o = sync_q;
endmodule

// File: rtl/gpio_irq_latch.sv
// gpio_irq_latch: sticky per-pin interrupt status and the interrupt line.
// An event sets its bit only if the pin is enabled in the mask and is in
// input mode. A clear pulse wipes every bit. An event in the same cycle as
// the clear survives it. Assumes clr_i is one cycle wide for each read.
module gpio_irq_latch #(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] event_i,
    input  logic [N_PINS-1:0] mask_i,
    input  logic [N_PINS-1:0] is_input_i,
    input  logic              clr_i,
    output logic [N_PINS-1:0] status_o,
    output logic              irq_o
);
    logic [N_PINS-1:0] status_q;
    logic [N_PINS-1:0] accept;

    // Work out which events this cycle are allowed to latch.
    always_comb accept = event_i & mask_i & is_input_i;

    // Sticky status: a read clears the old bits, and new events are always kept.
    always_ff @(posedge clk) begin
        if (!rst_n)     status_q <= '0;
        else if (clr_i) status_q <= accept;
        else            status_q <= status_q | accept;
    end

    // Interrupt line: some latched bit whose source is still enabled.
    always_comb irq_o = |(status_q & mask_i);

    assign status_o = status_q;

    for (genvar g = 0; g < N_PINS; g++) begin : g_chk
        // R4: a status bit only rises if its source was enabled.
        assert_masked_event_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[g]) |-> $past(mask_i[g]));
        // R5: a pin that is not in input mode never sets its status bit.
        assert_output_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[g]) |-> $past(is_input_i[g]));
        // R3: an enabled event is never lost.
        assert_event_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (event_i[g] && mask_i[g] && is_input_i[g]) |=> status_q[g]);
    end

    // R7 / R8: after a clear only same-cycle events remain.
    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((status_q & ~$past(event_i)) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
// gpio_irq_regs: register file and bus decode. Holds the mask register,
// gives a registered read path and issues the clear pulse when the status
// register is read. Assumes write and read strobes are never active together.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 4,
    parameter int AW     = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [N_PINS-1:0] level_i,
    input  logic [N_PINS-1:0] status_i,
    output logic [N_PINS-1:0] mask_o,
    output logic              clr_o,
    output logic [DW-1:0]     rdata_o
);
    localparam int PAD = DW - N_PINS;

    logic [N_PINS-1:0] mask_q;
    logic [DW-1:0]     rdata_q;
    logic [DW-1:0]     rd_mux;
    reg_sel_e          sel;

    // Decode the bus address into a register select.
    always_comb sel = decode_addr(addr_i[7:0]);

    // Mask register: only a write to its own address loads it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= '0;
        else if (wr_i && sel == SEL_MASK)  mask_q <= wdata_i[N_PINS-1:0];
    end

    // Read multiplexer, with the upper bits tied to zero.
    always_comb begin
        case (sel)
            SEL_MASK:   rd_mux = {{PAD{1'b0}}, mask_q};
            SEL_LEVEL:  rd_mux = {{PAD{1'b0}}, level_i};
            SEL_STATUS: rd_mux = {{PAD{1'b0}}, status_i};
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data, zero in any cycle that follows no read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
        else           rdata_q <= '0;
    end

    // A read of the status register clears it.
    always_comb clr_o = rd_i && (sel == SEL_STATUS);

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

    // R9: the mask changes only after a write to its own address.
    assert_mask_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_q) |-> $past(wr_i && addr_i == AW'(ADDR_MASK)));
    // R1: the reserved upper bits read as zero.
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_i && addr_i == AW'(ADDR_MASK)) |-> (rdata_q[DW-1:N_PINS] == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
// gpio_irq_unit: top level. Connects the pin synchroniser, the interrupt
// status latch and the register file. Assumes a single clock and a
// synchronous active-low reset. The input-mode flags come from outside.
module gpio_irq_unit #(
    parameter int N_PINS = 4,
    parameter int AW     = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] pin_is_input_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o
);
    logic [N_PINS-1:0] level;
    logic [N_PINS-1:0] events;
    logic [N_PINS-1:0] mask;
    logic [N_PINS-1:0] status;
    logic              clr;

    gpio_sync #(.N_PINS(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (level),
        .event_o (events)
    );

    gpio_irq_latch #(.N_PINS(N_PINS)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (events),
        .mask_i     (mask),
        .is_input_i (pin_is_input_i),
        .clr_i      (clr),
        .status_o   (status),
        .irq_o      (irq_o)
    );

    gpio_irq_regs #(.N_PINS(N_PINS), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .level_i  (level),
        .status_i (status),
        .mask_o   (mask),
        .clr_o    (clr),
        .rdata_o  (bus_rdata_o)
    );

    // R6: the interrupt line is never high without a latched status bit.
    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status != '0));
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = '0;
    logic [3:0] dir = '0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] m_mask = '0;
    logic [3:0] m_stat = '0;
    logic [3:0] m_pin  = '0;

    always #4 clk = ~clk;

    gpio_irq_unit u_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_is_input_i(dir),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [3:0] f_latch(input logic [3:0] st, input logic [3:0] oldp,
                                           input logic [3:0] newp, input logic [3:0] m,
                                           input logic [3:0] d);
        return st | ((oldp ^ newp) & m & d);
    endfunction

    function automatic logic f_irq(input logic [3:0] st, input logic [3:0] m);
        return |(st & m);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic apply_pins(input logic [3:0] p, input logic [3:0] dr);
        @(negedge clk);
        pin = p; dir = dr;
        m_stat = f_latch(m_stat, m_pin, p, m_mask, dr);
        m_pin = p;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        bus_read(8'h30, rv);
        check("R1 mask reset", rv, 8'h00);
        check("R9 idle rdata", rdata, 8'h00);

        // R4: a masked change is dropped.
        apply_pins(4'hF, 4'hF);
        check("R4 masked irq", {7'd0, irq}, 8'h00);
        bus_read(8'h33, rv);
        check("R4 masked status", rv, 8'h00);
        bus_read(8'h32, rv);
        check("R2 live level", rv, 8'h0F);

        // R1: the upper bits of the mask read as zero.
        bus_write(8'h30, 8'hFF);
        m_mask = 4'hF;
        bus_read(8'h30, rv);
        check("R1 reserved zero", rv, 8'h0F);

        // R10: falling edges count as events; R5: a pin not in input mode never latches.
        apply_pins(4'h0, 4'h7);
        check("R6 irq up", {7'd0, irq}, 8'h01);
        bus_read(8'h33, rv);
        check("R5 R10 falling status", rv, 8'h07);
        m_stat = '0;
        check("R7 irq after clear", {7'd0, irq}, 8'h00);
        bus_read(8'h33, rv);
        check("R7 cleared", rv, 8'h00);

        // R9: writes elsewhere are ignored, and unmapped reads return zero.
        bus_write(8'h31, 8'h00);
        bus_write(8'h33, 8'h0F);
        bus_read(8'h30, rv);
        check("R9 mask unchanged", rv, 8'h0F);
        bus_read(8'h33, rv);
        check("R9 status unchanged", rv, 8'h00);
        bus_read(8'h55, rv);
        check("R9 unmapped read", rv, 8'h00);

        // R6: clearing the mask drops irq while the status bit stays latched.
        apply_pins(4'h2, 4'hF);
        bus_write(8'h30, 8'h00);
        m_mask = 4'h0;
        check("R6 irq masked later", {7'd0, irq}, 8'h00);
        bus_write(8'h30, 8'h02);
        m_mask = 4'h2;
        check("R6 irq re-enabled", {7'd0, irq}, 8'h01);
        bus_read(8'h33, rv);
        check("R3 status kept", rv, 8'h02);
        m_stat = '0;

        // R8: an event arriving in the same cycle as the clearing read is kept.
        bus_write(8'h30, 8'h0F);
        m_mask = 4'hF;
        @(negedge clk);
        pin = 4'h3;
        m_pin = 4'h3;
        @(negedge clk);
        @(negedge clk);
        addr = 8'h33; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R8 read before event", rdata, 8'h00);
        check("R8 irq kept", {7'd0, irq}, 8'h01);
        bus_read(8'h33, rv);
        check("R8 event retained", rv, 8'h01);

        // R3 latency: the status bit is still clear two edges after the change.
        @(negedge clk);
        pin = 4'h7;
        m_pin = 4'h7;
        @(negedge clk);
        @(negedge clk);
        check("R3 not yet at edge 2", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R3 set at edge 3", {7'd0, irq}, 8'h01);
        bus_read(8'h33, rv);
        check("R3 latency status", rv, 8'h04);
        m_stat = '0;

        // Random mix of mask, mode flags and pin levels.
        for (int it = 0; it < 300; it++) begin
            logic [3:0] nm;
            logic [3:0] np;
            logic [3:0] nd;
            nm = 4'($urandom);
            np = 4'($urandom);
            nd = 4'($urandom);
            bus_write(8'h30, {4'($urandom), nm});
            m_mask = nm;
            apply_pins(np, nd);
            check("R6 random irq", {7'd0, irq}, {7'd0, f_irq(m_stat, m_mask)});
            bus_read(8'h32, rv);
            check("R2 random level", rv, {4'd0, m_pin});
            if (($urandom % 3) != 0) begin
                bus_read(8'h33, rv);
                check("R3 R4 R5 random status", rv, {4'd0, m_stat});
                m_stat = '0;
            end
        end
        finish_run();
    end
endmodule